// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the architectural state changes a 64-bit core makes when it accepts a general exception, that is, any exception other than cold reset, soft reset, NMI or the TLB refill. When the pipeline presents an accepted request, the block does the following:

- It records the exception code and the coprocessor number in the cause fields.
- It captures the restart address in the exception PC, together with the branch-delay flag. This happens only when the core is not already at exception level.
- It raises the exception-level bit.
- It writes the translation registers for the three TLB-related codes.
- It steers instruction fetch to the general exception vector.

The vector is chosen by the boot-vector status bit. The handler software, the TLB, the flush logic and any choice between simultaneous exceptions belong to the surrounding core.

All outputs are registers. The values belonging to a request sampled at one rising edge are visible from that same edge onward. A single-cycle pulse marks the fetch redirect.

Top module: `exc_entry_ctrl`

## Requirements
- R1: For each sampled request, `cause_code` and `cause_ce` show the request's code and coprocessor number after that edge. Without a request they hold their value.
- R2: A request with `status_exl`=0, `m16_mode`=0 and `in_delay_slot`=1 sets `bd` to 1 and sets `epc` to `fault_pc` minus 4.
- R3: A request with `status_exl`=0, `m16_mode`=0 and `in_delay_slot`=0 clears `bd` and sets `epc` to `fault_pc`.
- R4: A request with `status_exl`=0 and `m16_mode`=1 loads `epc` from `m16_restart_pc`, and `bd` follows `in_delay_slot`.
- R5: A request with `status_exl`=1 leaves `epc` and `bd` unchanged. So does any cycle without a request.
- R6: `exl` is 1 after any request. In a cycle without a request it takes the value of `status_exl`.
- R7: A request with `bev`=0 sets `fetch_pc` to FFFF_FFFF_8000_0180h.
- R8: A request with `bev`=1 sets `fetch_pc` to FFFF_FFFF_BFC0_0380h.
- R9: For code 1 (TLB modified), 2 (TLB load miss/invalid) or 3 (TLB store miss/invalid), the block loads three sets of registers: `entryhi_vpn2` and `ctx_badvpn2` with `fault_vaddr[39:13]`, `entryhi_asid` with `fault_asid`, and `badvaddr` with `fault_vaddr`.
- R10: Any other code, including 6 and 7 (bus errors), leaves `entryhi_vpn2`, `entryhi_asid`, `ctx_badvpn2` and `badvaddr` unchanged.
- R11: `redirect` is 1 for exactly the cycle after a sampled request and 0 otherwise. Without a request, `fetch_pc` holds its value.
- R12: A synchronous active-high `rst` clears every output register to zero, including `exl` and `bd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Accepted general exception this cycle |
| exc_code | input | 5 | Exception code |
| exc_ce | input | 2 | Coprocessor number for unusable-coprocessor faults |
| fault_pc | input | 64 | PC of the faulting instruction |
| in_delay_slot | input | 1 | Faulting instruction is in a branch delay slot |
| m16_mode | input | 1 | Core runs compressed 16-bit instructions |
| m16_restart_pc | input | 64 | Restart address supplied in compressed mode |
| fault_vaddr | input | 64 | Faulting virtual address |
| fault_asid | input | 8 | Current address-space identifier |
| status_exl | input | 1 | Current exception-level bit |
| bev | input | 1 | Boot-exception-vector select |
| epc | output | 64 | Exception PC |
| bd | output | 1 | Branch-delay flag for the cause register |
| cause_code | output | 5 | Recorded exception code |
| cause_ce | output | 2 | Recorded coprocessor number |
| exl | output | 1 | Updated exception-level bit |
| entryhi_vpn2 | output | 27 | EntryHi virtual page pair number |
| entryhi_asid | output | 8 | EntryHi address-space identifier |
| ctx_badvpn2 | output | 27 | Context bad page pair number field |
| badvaddr | output | 64 | Bad virtual address |
| fetch_pc | output | 64 | Redirected fetch address |
| redirect | output | 1 | One-cycle redirect pulse |

## Verification
Every output is a plain register loaded at the request edge, so a wrong capture condition shows one cycle later as a wrong `epc`, `bd` or translation-register value. Because these registers hold, the bad value then stays visible at the ports until the next qualifying request. The most revealing faults are an exception PC that is overwritten while EXL is set, and a `badvaddr` written on a bus error. Each of these persists, so a later check sees it even when the corrupting cycle itself went unchecked. A stuck or stretched `redirect` is visible on the very next cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   localparam logic [4:0] EXC_TLB_MOD  = 5'd1;
   localparam logic [4:0] EXC_TLB_LOAD = 5'd2;
   localparam logic [4:0] EXC_TLB_STOR = 5'd3;
   localparam logic [4:0] EXC_BUS_IFE  = 5'd6;
   localparam logic [4:0] EXC_BUS_DAT  = 5'd7;

   typedef struct packed {
      logic [4:0] code;
      logic [1:0] ce;
   } cause_t;

   function automatic logic is_tlb_code(input logic [4:0] code);
      return (code == EXC_TLB_MOD) || (code == EXC_TLB_LOAD) || (code == EXC_TLB_STOR);
   endfunction
endpackage

// File: rtl/exc_epc_sel.sv
module exc_epc_sel #(
   parameter int XLEN     = 64,
   parameter int INSN_BYT = 4
) (
   input  logic            req,
   input  logic            cur_exl,
   input  logic [XLEN-1:0] pc,
   input  logic            in_ds,
   input  logic            cmode,
   input  logic [XLEN-1:0] cmode_pc,
   output logic            capture,
   output logic [XLEN-1:0] epc_next,
   output logic            bd_next
);
   localparam logic [XLEN-1:0] BACKSTEP = XLEN'(INSN_BYT);

   logic [XLEN-1:0] pc_based;

   always_comb begin
      capture  = req && !cur_exl;
      pc_based = in_ds ? (pc - BACKSTEP) : pc;
      epc_next = cmode ? cmode_pc : pc_based;
      bd_next  = in_ds;
   end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
   parameter int              XLEN      = 64,
   parameter logic [XLEN-1:0] BASE_NORM = 64'hFFFF_FFFF_8000_0000,
   parameter logic [XLEN-1:0] BASE_BOOT = 64'hFFFF_FFFF_BFC0_0200,
   parameter logic [XLEN-1:0] VEC_OFFS  = 64'h180,
   parameter bit              BOOT_SEL  = 1'b1
) (
   input  logic            bev,
   output logic [XLEN-1:0] vector
);
   localparam logic [XLEN-1:0] VEC_NORM = BASE_NORM + VEC_OFFS;
   localparam logic [XLEN-1:0] VEC_BOOT = BASE_BOOT + VEC_OFFS;

   generate
      if (BOOT_SEL) begin : g_dual
         assign vector = bev ? VEC_BOOT : VEC_NORM;
      end else begin : g_single
         logic unused_bev;
         assign unused_bev = bev;
         assign vector     = VEC_NORM;
      end
   endgenerate
endmodule

// File: rtl/exc_tlb_capture.sv
module exc_tlb_capture
   import exc_entry_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int ASID_W   = 8,
   parameter int VPN2_HI  = 39,
   parameter int VPN2_LO  = 13,
   parameter bit TLB_REGS = 1'b1,
   localparam int VPN2_W  = VPN2_HI - VPN2_LO + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic [4:0]        code,
   input  logic [XLEN-1:0]   vaddr,
   input  logic [ASID_W-1:0] asid,
   output logic [VPN2_W-1:0] hi_vpn2,
   output logic [ASID_W-1:0] hi_asid,
   output logic [VPN2_W-1:0] ctx_vpn2,
   output logic [XLEN-1:0]   bad_va
);
   generate
      if (TLB_REGS) begin : g_regs
         logic load;
         assign load = req && is_tlb_code(code);

         always_ff @(posedge clk) begin
            if (rst) begin
               hi_vpn2  <= '0;
               hi_asid  <= '0;
               ctx_vpn2 <= '0;
               bad_va   <= '0;
            end else if (load) begin
               hi_vpn2  <= vaddr[VPN2_HI:VPN2_LO];
               hi_asid  <= asid;
               ctx_vpn2 <= vaddr[VPN2_HI:VPN2_LO];
               bad_va   <= vaddr;
            end
         end
      end else begin : g_none
         logic unused_in;
         assign unused_in = clk ^ rst ^ req ^ (^code) ^ (^vaddr) ^ (^asid);
         assign hi_vpn2   = '0;
         assign hi_asid   = '0;
         assign ctx_vpn2  = '0;
         assign bad_va    = '0;
      end
   endgenerate
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int              XLEN      = 64,
   parameter int              ASID_W    = 8,
   parameter int              VPN2_HI   = 39,
   parameter int              VPN2_LO   = 13,
   parameter int              INSN_BYT  = 4,
   parameter logic [XLEN-1:0] BASE_NORM = 64'hFFFF_FFFF_8000_0000,
   parameter logic [XLEN-1:0] BASE_BOOT = 64'hFFFF_FFFF_BFC0_0200,
   parameter logic [XLEN-1:0] VEC_OFFS  = 64'h180,
   parameter bit              BOOT_SEL  = 1'b1,
   parameter bit              TLB_REGS  = 1'b1,
   localparam int             VPN2_W    = VPN2_HI - VPN2_LO + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              exc_req,
   input  logic [4:0]        exc_code,
   input  logic [1:0]        exc_ce,
   input  logic [XLEN-1:0]   fault_pc,
   input  logic              in_delay_slot,
   input  logic              m16_mode,
   input  logic [XLEN-1:0]   m16_restart_pc,
   input  logic [XLEN-1:0]   fault_vaddr,
   input  logic [ASID_W-1:0] fault_asid,
   input  logic              status_exl,
   input  logic              bev,
   output logic [XLEN-1:0]   epc,
   output logic              bd,
   output logic [4:0]        cause_code,
   output logic [1:0]        cause_ce,
   output logic              exl,
   output logic [VPN2_W-1:0] entryhi_vpn2,
   output logic [ASID_W-1:0] entryhi_asid,
   output logic [VPN2_W-1:0] ctx_badvpn2,
   output logic [XLEN-1:0]   badvaddr,
   output logic [XLEN-1:0]   fetch_pc,
   output logic              redirect
);
   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("exc_entry_ctrl: XLEN must be at least 32");
      end
      if (VPN2_HI >= XLEN || VPN2_LO < 1 || VPN2_HI < VPN2_LO) begin : g_bad_vpn
         $error("exc_entry_ctrl: VPN2 field outside the address");
      end
      if (ASID_W < 1) begin : g_bad_asid
         $error("exc_entry_ctrl: ASID_W must be positive");
      end
      if (INSN_BYT != 2 && INSN_BYT != 4) begin : g_bad_insn
         $error("exc_entry_ctrl: INSN_BYT must be 2 or 4");
      end
   endgenerate

   logic            capture;
   logic [XLEN-1:0] epc_next;
   logic            bd_next;
   logic [XLEN-1:0] vector;
   cause_t          cause_q;

   exc_epc_sel #(
      .XLEN     (XLEN),
      .INSN_BYT (INSN_BYT)
   ) u_epc_sel (
      .req      (exc_req),
      .cur_exl  (status_exl),
      .pc       (fault_pc),
      .in_ds    (in_delay_slot),
      .cmode    (m16_mode),
      .cmode_pc (m16_restart_pc),
      .capture  (capture),
      .epc_next (epc_next),
      .bd_next  (bd_next)
   );

   exc_vector_gen #(
      .XLEN      (XLEN),
      .BASE_NORM (BASE_NORM),
      .BASE_BOOT (BASE_BOOT),
      .VEC_OFFS  (VEC_OFFS),
      .BOOT_SEL  (BOOT_SEL)
   ) u_vec (
      .bev    (bev),
      .vector (vector)
   );

   exc_tlb_capture #(
      .XLEN     (XLEN),
      .ASID_W   (ASID_W),
      .VPN2_HI  (VPN2_HI),
      .VPN2_LO  (VPN2_LO),
      .TLB_REGS (TLB_REGS)
   ) u_tlb (
      .clk      (clk),
      .rst      (rst),
      .req      (exc_req),
      .code     (exc_code),
      .vaddr    (fault_vaddr),
      .asid     (fault_asid),
      .hi_vpn2  (entryhi_vpn2),
      .hi_asid  (entryhi_asid),
      .ctx_vpn2 (ctx_badvpn2),
      .bad_va   (badvaddr)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         epc <= '0;
         bd  <= 1'b0;
      end else if (capture) begin
         epc <= epc_next;
         bd  <= bd_next;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cause_q  <= '0;
         fetch_pc <= '0;
      end else if (exc_req) begin
         cause_q  <= '{code: exc_code, ce: exc_ce};
         fetch_pc <= vector;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         exl      <= 1'b0;
         redirect <= 1'b0;
      end else begin
         exl      <= exc_req | status_exl;
         redirect <= exc_req;
      end
   end

   assign cause_code = cause_q.code;
   assign cause_ce   = cause_q.ce;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int              XLEN      = 64,
   parameter int              ASID_W    = 8,
   parameter int              VPN2_HI   = 39,
   parameter int              VPN2_LO   = 13,
   parameter logic [XLEN-1:0] VEC_NORM  = 64'hFFFF_FFFF_8000_0180,
   parameter logic [XLEN-1:0] VEC_BOOT  = 64'hFFFF_FFFF_BFC0_0380,
   localparam int             VPN2_W    = VPN2_HI - VPN2_LO + 1
) (
   input logic              clk,
   input logic              rst,
   input logic              exc_req,
   input logic [4:0]        exc_code,
   input logic [1:0]        exc_ce,
   input logic [XLEN-1:0]   fault_pc,
   input logic              in_delay_slot,
   input logic              m16_mode,
   input logic [XLEN-1:0]   m16_restart_pc,
   input logic [XLEN-1:0]   fault_vaddr,
   input logic [ASID_W-1:0] fault_asid,
   input logic              status_exl,
   input logic              bev,
   input logic [XLEN-1:0]   epc,
   input logic              bd,
   input logic [4:0]        cause_code,
   input logic [1:0]        cause_ce,
   input logic              exl,
   input logic [VPN2_W-1:0] entryhi_vpn2,
   input logic [ASID_W-1:0] entryhi_asid,
   input logic [VPN2_W-1:0] ctx_badvpn2,
   input logic [XLEN-1:0]   badvaddr,
   input logic [XLEN-1:0]   fetch_pc,
   input logic              redirect
);
   logic tlb_req;
   assign tlb_req = exc_req && (exc_code inside {5'd1, 5'd2, 5'd3});

   a_r1_cause: assert property (@(posedge clk) disable iff (rst)
      exc_req |=> (cause_code == $past(exc_code)) && (cause_ce == $past(exc_ce)));

   a_r2_delay_slot: assert property (@(posedge clk) disable iff (rst)
      (exc_req && !status_exl && !m16_mode && in_delay_slot)
      |=> bd && (epc == $past(fault_pc) - XLEN'(4)));

   a_r3_plain: assert property (@(posedge clk) disable iff (rst)
      (exc_req && !status_exl && !m16_mode && !in_delay_slot)
      |=> !bd && (epc == $past(fault_pc)));

   a_r4_compressed: assert property (@(posedge clk) disable iff (rst)
      (exc_req && !status_exl && m16_mode)
      |=> (epc == $past(m16_restart_pc)) && (bd == $past(in_delay_slot)));

   a_r5_nested_hold: assert property (@(posedge clk) disable iff (rst)
      (!exc_req || status_exl) |=> $stable(epc) && $stable(bd));

   a_r6_exl_set: assert property (@(posedge clk) disable iff (rst)
      exc_req |=> exl);

   a_r6_exl_follow: assert property (@(posedge clk) disable iff (rst)
      !exc_req |=> (exl == $past(status_exl)));

   a_r7_vec_norm: assert property (@(posedge clk) disable iff (rst)
      (exc_req && !bev) |=> (fetch_pc == VEC_NORM));

   a_r8_vec_boot: assert property (@(posedge clk) disable iff (rst)
      (exc_req && bev) |=> (fetch_pc == VEC_BOOT));

   a_r9_tlb_regs: assert property (@(posedge clk) disable iff (rst)
      tlb_req |=> (badvaddr == $past(fault_vaddr))
                 && (entryhi_vpn2 == $past(fault_vaddr[VPN2_HI:VPN2_LO]))
                 && (ctx_badvpn2 == $past(fault_vaddr[VPN2_HI:VPN2_LO]))
                 && (entryhi_asid == $past(fault_asid)));

   a_r10_tlb_hold: assert property (@(posedge clk) disable iff (rst)
      !tlb_req |=> $stable(badvaddr) && $stable(entryhi_vpn2)
                  && $stable(ctx_badvpn2) && $stable(entryhi_asid));

   a_r11_pulse: assert property (@(posedge clk) disable iff (rst)
      exc_req |=> redirect);

   a_r11_quiet: assert property (@(posedge clk) disable iff (rst)
      !exc_req |=> !redirect && $stable(fetch_pc));

   a_r12_reset: assert property (@(posedge clk)
      rst |=> !exl && !bd && !redirect && (epc == '0) && (badvaddr == '0));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
   .XLEN     (XLEN),
   .ASID_W   (ASID_W),
   .VPN2_HI  (VPN2_HI),
   .VPN2_LO  (VPN2_LO),
   .VEC_NORM (BASE_NORM + VEC_OFFS),
   .VEC_BOOT (BASE_BOOT + VEC_OFFS)
) u_chk (
   .clk            (clk),
   .rst            (rst),
   .exc_req        (exc_req),
   .exc_code       (exc_code),
   .exc_ce         (exc_ce),
   .fault_pc       (fault_pc),
   .in_delay_slot  (in_delay_slot),
   .m16_mode       (m16_mode),
   .m16_restart_pc (m16_restart_pc),
   .fault_vaddr    (fault_vaddr),
   .fault_asid     (fault_asid),
   .status_exl     (status_exl),
   .bev            (bev),
   .epc            (epc),
   .bd             (bd),
   .cause_code     (cause_code),
   .cause_ce       (cause_ce),
   .exl            (exl),
   .entryhi_vpn2   (entryhi_vpn2),
   .entryhi_asid   (entryhi_asid),
   .ctx_badvpn2    (ctx_badvpn2),
   .badvaddr       (badvaddr),
   .fetch_pc       (fetch_pc),
   .redirect       (redirect)
);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
   logic        clk = 1'b0;
   logic        rst;
   logic        exc_req;
   logic [4:0]  exc_code;
   logic [1:0]  exc_ce;
   logic [63:0] fault_pc;
   logic        in_delay_slot;
   logic        m16_mode;
   logic [63:0] m16_restart_pc;
   logic [63:0] fault_vaddr;
   logic [7:0]  fault_asid;
   logic        status_exl;
   logic        bev;
   logic [63:0] epc;
   logic        bd;
   logic [4:0]  cause_code;
   logic [1:0]  cause_ce;
   logic        exl;
   logic [26:0] entryhi_vpn2;
   logic [7:0]  entryhi_asid;
   logic [26:0] ctx_badvpn2;
   logic [63:0] badvaddr;
   logic [63:0] fetch_pc;
   logic        redirect;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   localparam logic [63:0] V_NORM = 64'hFFFF_FFFF_8000_0180;
   localparam logic [63:0] V_BOOT = 64'hFFFF_FFFF_BFC0_0380;

   always #10 clk = ~clk;

   exc_entry_ctrl dut (.*);

   logic [63:0] m_epc, m_bva, m_fpc;
   logic        m_bd, m_exl, m_redir;
   logic [4:0]  m_code;
   logic [1:0]  m_ce;
   logic [26:0] m_vpn2, m_ctx;
   logic [7:0]  m_asid;
   string       t_epc, t_tlb, t_fpc, t_exl;

   function automatic bit tlb_code(input logic [4:0] c);
      return (c == 5'd1) || (c == 5'd2) || (c == 5'd3);
   endfunction

   function automatic logic [63:0] exp_epc(input logic [63:0] pc, input logic ds,
                                           input logic cm, input logic [63:0] rpc);
      if (cm) return rpc;
      return ds ? pc - 64'd4 : pc;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_epc = '0; m_bva = '0; m_fpc = '0; m_bd = 0; m_exl = 0; m_redir = 0;
      m_code = '0; m_ce = '0; m_vpn2 = '0; m_ctx = '0; m_asid = '0;
   endtask

   task automatic model_step();
      t_epc = "R5"; t_tlb = "R10"; t_fpc = "R11"; t_exl = "R6";
      if (rst) begin
         model_reset();
         t_epc = "R12"; t_tlb = "R12"; t_fpc = "R12"; t_exl = "R12";
         return;
      end
      m_redir = exc_req;
      m_exl   = exc_req | status_exl;
      if (exc_req) begin
         m_code = exc_code;
         m_ce   = exc_ce;
         m_fpc  = bev ? V_BOOT : V_NORM;
         t_fpc  = bev ? "R8" : "R7";
         if (!status_exl) begin
            m_epc = exp_epc(fault_pc, in_delay_slot, m16_mode, m16_restart_pc);
            m_bd  = in_delay_slot;
            t_epc = m16_mode ? "R4" : (in_delay_slot ? "R2" : "R3");
         end
         if (tlb_code(exc_code)) begin
            m_bva  = fault_vaddr;
            m_vpn2 = fault_vaddr[39:13];
            m_ctx  = fault_vaddr[39:13];
            m_asid = fault_asid;
            t_tlb  = "R9";
         end
      end
   endtask

   task automatic compare();
      chk({t_epc, " epc"}, epc, m_epc);
      chk({t_epc, " bd"}, 64'(bd), 64'(m_bd));
      chk("R1 cause", {57'd0, cause_ce, cause_code}, {57'd0, m_ce, m_code});
      chk({t_exl, " exl"}, 64'(exl), 64'(m_exl));
      chk({t_tlb, " badvaddr"}, badvaddr, m_bva);
      chk({t_tlb, " entryhi"}, {29'd0, entryhi_asid, entryhi_vpn2}, {29'd0, m_asid, m_vpn2});
      chk({t_tlb, " context"}, 64'(ctx_badvpn2), 64'(m_ctx));
      chk({t_fpc, " fetch_pc"}, fetch_pc, m_fpc);
      chk({(t_exl == "R12") ? "R12" : "R11", " redirect"}, 64'(redirect), 64'(m_redir));
   endtask

   task automatic cycle();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic drive(input logic rq, input logic [4:0] c, input logic ds, input logic cm,
                        input logic ex, input logic bv);
      exc_req = rq; exc_code = c; in_delay_slot = ds; m16_mode = cm;
      status_exl = ex; bev = bv;
      exc_ce = 2'($urandom);
      fault_pc = {$urandom, $urandom} & ~64'h3;
      m16_restart_pc = {$urandom, $urandom} | 64'h1;
      fault_vaddr = {$urandom, $urandom};
      fault_asid = 8'($urandom);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      rst = 1'b1;
      drive(0, 0, 0, 0, 0, 0);
      model_reset();
      cycle();
      cycle();
      rst = 1'b0;
      // R12 reset state, then directed corners
      drive(1, 5'd2, 1, 0, 0, 0); cycle();   // R2 R7 R9
      drive(1, 5'd7, 0, 0, 0, 1); cycle();   // R3 R8 R10 bus error
      drive(1, 5'd6, 1, 0, 0, 0); cycle();   // R10 bus error
      drive(1, 5'd11, 1, 1, 0, 1); cycle();  // R4
      drive(1, 5'd1, 0, 0, 1, 0); cycle();   // R5 nested, R9
      drive(0, 5'd3, 0, 0, 0, 0); cycle();   // R11 quiet, R6 follow
      drive(1, 5'd3, 0, 1, 0, 1); cycle();   // R4 without delay slot
      for (int i = 0; i < 3000; i++) begin
         int r;
         logic [4:0] c;
         r = int'($urandom_range(0, 9));
         c = (r < 4) ? 5'(r) : (r < 6) ? 5'(6 + r[0]) : 5'($urandom);
         drive($urandom_range(0, 2) != 0, c, 1'($urandom), $urandom_range(0, 3) == 0,
               $urandom_range(0, 3) == 0, 1'($urandom));
         if (i == 1500) rst = 1'b1;
         if (i == 1502) rst = 1'b0;
         cycle();
      end
      done = 1'b1;
   end

   initial begin
      for (int k = 0; k < 100000; k++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule